// File: doc/BRIEF.md
# Burst Line Write Bus Master

This block is the bus-master sequencer that writes one cache line of four 32-bit long words onto a synchronous processor bus. When the block is idle and a line write is requested, it captures the line address, the transfer attributes, the lock request and the whole line of data. It then opens a bus cycle with a one-clock start strobe and the line size code, and holds transfer-in-progress for as long as the line is being written.

Each long word is written when the slave acknowledges the beat. The long-word select bits of the address step after each acknowledge and wrap within the line, so a line may start at any long word. The burst-inhibit input is sampled on the first acknowledge of the line. If it is set then, each of the three long words that remain is written in its own long-word bus cycle, and each such cycle has its own start strobe and its own stepped address. A status-acknowledge output marks the cycles in which an acknowledge is accepted. When the ignore-state option is enabled, that output is held off for a primary count of wait cycles on the first beat and for a secondary count on each later beat.

Top module: `line_wr_master`

## Requirements
- R1: While reset is applied and after it is released, tip_o, start_o, sas_o, lock_o and done_o are 0 and rnw_o is 1.
- R2: A request taken in idle leads, in the next cycle, to start_o=1, tip_o=1, rnw_o=0, size_o=2'b11 (line), addr_o equal to the requested address and attr_o equal to the requested attributes.
- R3: start_o is high for exactly one clock at the start of each bus cycle and is never high in two cycles in a row.
- R4: ta_i has no effect in a cycle where sas_o is 0, and this includes the start cycle and the ignore wait cycles.
- R5: An acknowledged beat writes long word k of line_i, which is bits 32k+31:32k, where k equals addr_o[3:2]. After each acknowledge, addr_o[3:2] increments modulo 4, starting from the requested value, until four words have been written. Address bits 31:4 and 1:0 do not change.
- R6: If tbi_i=1 on the first accepted acknowledge, each of the remaining three words gets a new bus cycle with its own start_o pulse, size_o=2'b00 (long word) and the incremented address.
- R7: tbi_i is ignored on the second, third and fourth acknowledges. The line then stays one burst with a single start_o.
- R8: With ign_en_i=0, sas_o is 1 in every data cycle. With ign_en_i=1 (captured at the request), sas_o goes high after ign_pri_i data cycles for the first beat and after ign_sec_i data cycles for each later beat.
- R9: tip_o stays 1 from the start cycle through the final acknowledge and falls only together with a one-clock done_o pulse in the cycle after that acknowledge.
- R10: lock_o equals the captured lock_i for the whole line and is 0 once the line completes.
- R11: A request made while a line is in progress is ignored. A request present at the final acknowledge is taken back to back, so tip_o stays 1 and start_o rises in the same cycle as done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Line write request |
| addr_i | input | 32 | Line address; bits 3:2 select the first long word |
| attr_i | input | 8 | Transfer attributes |
| lock_i | input | 1 | Request a locked line |
| line_i | input | 128 | Line data, long word k in bits 32k+31:32k |
| ign_en_i | input | 1 | Enable acknowledge ignore counting |
| ign_pri_i | input | 4 | Wait cycles before the first beat |
| ign_sec_i | input | 4 | Wait cycles before each later beat |
| ta_i | input | 1 | Transfer acknowledge from the slave |
| tbi_i | input | 1 | Burst inhibit from the slave |
| addr_o | output | 32 | Bus address |
| attr_o | output | 8 | Bus transfer attributes |
| size_o | output | 2 | Size code: 2'b11 line, 2'b00 long word |
| rnw_o | output | 1 | Direction, 0 = write |
| start_o | output | 1 | Transfer start strobe |
| tip_o | output | 1 | Transfer in progress |
| sas_o | output | 1 | Status acknowledge: acknowledge accepted this cycle |
| data_o | output | 32 | Write data |
| lock_o | output | 1 | Bus lock |
| done_o | output | 1 | Line complete pulse |

## Verification
Two events can fall in the same cycle: the final acknowledge of a line and a new request. The test raises req_i in exactly the cycle of the fourth accepted acknowledge. The cycle that follows is then judged: done_o, tip_o and start_o must all be high, and the new address must already be on the bus. A second case pairs burst-inhibit with a later-beat acknowledge. Here tbi_i is held high only after the first acknowledge, and the line must still show a single start strobe.

// File: rtl/lwm_pkg.sv
package lwm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } lwm_state_e;

  localparam logic [1:0] SIZE_LONG = 2'b00;
  localparam logic [1:0] SIZE_LINE = 2'b11;
endpackage

// File: rtl/lwm_ign_timer.sv
module lwm_ign_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/lwm_addr_step.sv
module lwm_addr_step #(
  parameter int IW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [IW-1:0] load_val_i,
  input  logic          step_i,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] idx_q;

  // wraps modulo the line length
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (load_i)  idx_q <= load_val_i;
    else if (step_i)  idx_q <= idx_q + 1'b1;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/lwm_fsm.sv
module lwm_fsm
  import lwm_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       ta_i,
  input  logic       tbi_i,
  input  logic       sas_i,
  output lwm_state_e state_o,
  output logic       accept_o,
  output logic       ack_o,
  output logic       last_o,
  output logic       inh_o,
  output logic       done_o
);
  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;

  lwm_state_e    state_q, state_d;
  logic [BW-1:0] beat_q;
  logic          inh_q, done_q, inh_next;

  assign ack_o    = (state_q == ST_DATA) && ta_i && sas_i;
  assign last_o   = ack_o && (beat_q == BW'(BEATS - 1));
  assign accept_o = req_i && ((state_q == ST_IDLE) || last_o);
  // inhibit decided only on the first acknowledge
  assign inh_next = (beat_q == '0) ? tbi_i : inh_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_o) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: begin
        if (last_o)     state_d = accept_o ? ST_ADDR : ST_IDLE;
        else if (ack_o) state_d = inh_next ? ST_ADDR : ST_DATA;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      inh_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= last_o;
      if (accept_o) begin
        beat_q <= '0;
        inh_q  <= 1'b0;
      end else if (ack_o) begin
        beat_q <= beat_q + 1'b1;
        inh_q  <= inh_next;
      end
    end
  end

  assign state_o = state_q;
  assign inh_o   = inh_q;
  assign done_o  = done_q;
endmodule

// File: rtl/line_wr_master.sv
module line_wr_master
  import lwm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4,
  parameter int ATTR_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [ATTR_W-1:0]        attr_i,
  input  logic                     lock_i,
  input  logic [DATA_W*BEATS-1:0]  line_i,
  input  logic                     ign_en_i,
  input  logic [CNT_W-1:0]         ign_pri_i,
  input  logic [CNT_W-1:0]         ign_sec_i,
  input  logic                     ta_i,
  input  logic                     tbi_i,
  output logic [ADDR_W-1:0]        addr_o,
  output logic [ATTR_W-1:0]        attr_o,
  output logic [1:0]               size_o,
  output logic                     rnw_o,
  output logic                     start_o,
  output logic                     tip_o,
  output logic                     sas_o,
  output logic [DATA_W-1:0]        data_o,
  output logic                     lock_o,
  output logic                     done_o
);
  localparam int IW     = $clog2(BEATS);
  localparam int LSB    = $clog2(DATA_W / 8);
  localparam int LINE_W = DATA_W * BEATS;

  lwm_state_e        state;
  logic              accept, ack, last, inh, expired;
  logic [IW-1:0]     idx;
  logic [ADDR_W-1:0] base_q;
  logic [ATTR_W-1:0] attr_q;
  logic [LINE_W-1:0] line_q;
  logic              lock_q, en_q;
  logic [CNT_W-1:0]  sec_q;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;

  lwm_fsm #(.BEATS(BEATS)) u_fsm (
    .clk_i, .rst_ni, .req_i, .ta_i, .tbi_i,
    .sas_i    (sas_o),
    .state_o  (state),
    .accept_o (accept),
    .ack_o    (ack),
    .last_o   (last),
    .inh_o    (inh),
    .done_o   (done_o)
  );

  lwm_addr_step #(.IW(IW)) u_addr (
    .clk_i, .rst_ni,
    .load_i     (accept),
    .load_val_i (addr_i[LSB +: IW]),
    .step_i     (ack),
    .idx_o      (idx)
  );

  // new line loads the primary count, later beats the secondary
  assign tmr_load = accept || (ack && !last);
  assign tmr_val  = accept ? (ign_en_i ? ign_pri_i : '0)
                           : (en_q ? sec_q : '0);

  lwm_ign_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni,
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .run_i      (state == ST_DATA),
    .expired_o  (expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      attr_q <= '0;
      line_q <= '0;
      lock_q <= 1'b0;
      en_q   <= 1'b0;
      sec_q  <= '0;
    end else if (accept) begin
      base_q <= addr_i;
      attr_q <= attr_i;
      line_q <= line_i;
      lock_q <= lock_i;
      en_q   <= ign_en_i;
      sec_q  <= ign_sec_i;
    end else if (last) begin
      lock_q <= 1'b0;
    end
  end

  assign addr_o  = {base_q[ADDR_W-1:LSB+IW], idx, base_q[LSB-1:0]};
  assign attr_o  = attr_q;
  assign data_o  = line_q[int'(idx)*DATA_W +: DATA_W];
  assign size_o  = inh ? SIZE_LONG : SIZE_LINE;
  assign tip_o   = (state != ST_IDLE);
  assign rnw_o   = !tip_o;
  assign start_o = (state == ST_ADDR);
  assign sas_o   = (state == ST_DATA) && expired;
  assign lock_o  = lock_q;

  AST_START_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R3
  AST_TIP_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tip_o) |-> start_o); // R2
  AST_TIP_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tip_o) |-> done_o); // R9
  AST_DONE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && !last) |=> idx == IW'($past(idx) + 1'b1)); // R5
  AST_LOCK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tip_o |-> !lock_o); // R10
endmodule

// File: tb/sim_line_wr_master.sv
module sim_line_wr_master;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] a;
    logic        en;
    logic [3:0]  pri;
    logic [3:0]  sec;
    logic [1:0]  tbm;  // 0 none, 1 always, 2 only after first ack
    logic        lk;
    logic        tam;  // 1: ta alternates
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h1000_0000, 1'b0, 4'd0, 4'd0, 2'd0, 1'b0, 1'b0},
    '{32'h2000_000C, 1'b0, 4'd0, 4'd0, 2'd1, 1'b1, 1'b0},
    '{32'h3000_0004, 1'b1, 4'd3, 4'd1, 2'd0, 1'b0, 1'b0},
    '{32'h4000_0008, 1'b1, 4'd0, 4'd2, 2'd1, 1'b1, 1'b0},
    '{32'h5000_0000, 1'b0, 4'd5, 4'd5, 2'd2, 1'b0, 1'b0},
    '{32'h6000_0007, 1'b1, 4'd1, 4'd0, 2'd0, 1'b1, 1'b1}
  };

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         req_i = 1'b0, lock_i = 1'b0, ign_en_i = 1'b0, ta_i = 1'b0, tbi_i = 1'b0;
  logic [31:0]  addr_i = '0;
  logic [7:0]   attr_i = '0;
  logic [127:0] line_i = '0;
  logic [3:0]   ign_pri_i = '0, ign_sec_i = '0;
  logic [31:0]  addr_o, data_o;
  logic [7:0]   attr_o;
  logic [1:0]   size_o;
  logic         rnw_o, start_o, tip_o, sas_o, lock_o, done_o;
  int           total = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_wr_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i, .addr_i, .attr_i, .lock_i, .line_i,
    .ign_en_i, .ign_pri_i, .ign_sec_i, .ta_i, .tbi_i,
    .addr_o, .attr_o, .size_o, .rnw_o, .start_o, .tip_o, .sas_o, .data_o,
    .lock_o, .done_o
  );

  task automatic chk(input bit ok, input string rq, input string msg,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, msg, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input int n, input int k);
    return 32'hA000_0000 | (32'(n) << 8) | 32'(k);
  endfunction

  function automatic logic [127:0] mkline(input int n);
    logic [127:0] l;
    for (int k = 0; k < 4; k++) l[k*32 +: 32] = word(n, k);
    return l;
  endfunction

  function automatic logic [31:0] mkaddr(input logic [31:0] a, input int idx);
    return {a[31:4], 2'(idx), a[1:0]};
  endfunction

  task automatic run_line(input int n, input vec_t v, input bit poke,
                          input bit b2b, input bit skip_req);
    int beats = 0, starts = 0, tipc = 0, waits = 0, cyc = 0, exp_tip, exp_w;
    bit inh = 0, prev_start = 0;
    int s = int'(v.a[3:2]);
    logic [7:0] at = 8'(n) ^ 8'h5A;
    if (!skip_req) begin
      @(negedge clk);
      req_i = 1'b1; addr_i = v.a; attr_i = at; lock_i = v.lk; line_i = mkline(n);
      ign_en_i = v.en; ign_pri_i = v.pri; ign_sec_i = v.sec;
      @(negedge clk);
    end
    req_i = 1'b0;
    while (beats < 4 && cyc < 400) begin
      ta_i  = v.tam ? cyc[0] : 1'b1;
      tbi_i = (v.tbm == 2'd1) || (v.tbm == 2'd2 && beats > 0);
      if (poke) req_i = 1'b0;
      tipc += int'(tip_o);
      chk(tip_o === 1'b1, "R9", "tip held during line", 64'(tip_o), 64'd1);
      chk(lock_o === v.lk, "R10", "lock during line", 64'(lock_o), 64'(v.lk));
      if (start_o) begin
        starts++;
        chk(!prev_start, "R3", "start two cycles in a row", 64'd1, 64'd0);
        chk(addr_o === mkaddr(v.a, (s + beats) % 4), "R2", "start address",
            64'(addr_o), 64'(mkaddr(v.a, (s + beats) % 4)));
        chk(size_o === ((beats == 0) ? 2'b11 : 2'b00), "R6", "size at start",
            64'(size_o), 64'((beats == 0) ? 2'b11 : 2'b00));
        chk(rnw_o === 1'b0 && attr_o === at, "R2", "direction/attributes",
            64'({rnw_o, attr_o}), 64'({1'b0, at}));
        chk(!sas_o, "R4", "sas in start cycle", 64'(sas_o), 64'd0);
      end else if (sas_o && ta_i) begin
        exp_w = v.en ? ((beats == 0) ? int'(v.pri) : int'(v.sec)) : 0;
        chk(waits == exp_w, "R8", "ignore wait cycles", 64'(waits), 64'(exp_w));
        chk(data_o === word(n, (s + beats) % 4), "R5", "beat data",
            64'(data_o), 64'(word(n, (s + beats) % 4)));
        chk(addr_o === mkaddr(v.a, (s + beats) % 4), "R5", "beat address",
            64'(addr_o), 64'(mkaddr(v.a, (s + beats) % 4)));
        chk(size_o === ((beats == 0 || !inh) ? 2'b11 : 2'b00), "R6", "size at beat",
            64'(size_o), 64'((beats == 0 || !inh) ? 2'b11 : 2'b00));
        if (beats == 0) inh = tbi_i;
        beats++;
        waits = 0;
        if (poke && beats == 1) begin
          req_i = 1'b1; addr_i = 32'hDEAD_0000; line_i = ~mkline(n);
        end
        if (b2b && beats == 4) begin
          req_i = 1'b1; addr_i = 32'h0000_2004; attr_i = 8'(n + 1) ^ 8'h5A;
          lock_i = 1'b0; line_i = mkline(n + 1); ign_en_i = 1'b0;
        end
      end else if (!sas_o) begin
        waits++;
      end
      prev_start = start_o;
      cyc++;
      @(negedge clk);
    end
    chk(beats == 4, "R5", "beats written", 64'(beats), 64'd4);
    exp_tip = ((v.tbm == 2'd1) ? 4 : 1) + (v.en ? int'(v.pri) : 0) + 1
              + 3 * ((v.en ? int'(v.sec) : 0) + 1);
    if (!v.tam)
      chk(tipc == exp_tip, "R8", "cycles in line", 64'(tipc), 64'(exp_tip));
    chk(starts == ((v.tbm == 2'd1) ? 4 : 1), (v.tbm == 2'd2) ? "R7" : (poke ? "R11" : "R6"),
        "start strobes", 64'(starts), 64'((v.tbm == 2'd1) ? 4 : 1));
    chk(done_o === 1'b1, "R9", "done after final ack", 64'(done_o), 64'd1);
    if (b2b) begin
      chk(tip_o === 1'b1 && start_o === 1'b1, "R11", "back-to-back start",
          64'({tip_o, start_o}), 64'b11);
      chk(addr_o === 32'h0000_2004, "R11", "back-to-back address", 64'(addr_o), 64'h2004);
    end else begin
      chk(tip_o === 1'b0 && lock_o === 1'b0, "R10", "tip/lock after line",
          64'({tip_o, lock_o}), 64'd0);
      @(negedge clk);
      chk(done_o === 1'b0, "R9", "done one clock", 64'(done_o), 64'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    vec_t w;
    #(CLK_PERIOD * 2 + 1);
    chk({tip_o, start_o, sas_o, lock_o, done_o, rnw_o} === 6'b000001, "R1", "in reset",
        64'({tip_o, start_o, sas_o, lock_o, done_o, rnw_o}), 64'b1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({tip_o, start_o, sas_o, lock_o, done_o, rnw_o} === 6'b000001, "R1", "after reset",
        64'({tip_o, start_o, sas_o, lock_o, done_o, rnw_o}), 64'b1);
    for (int i = 0; i < 6; i++) run_line(i + 1, VECS[i], 1'b0, 1'b0, 1'b0);
    // request while busy is ignored
    w = '{32'h7000_0004, 1'b0, 4'd0, 4'd0, 2'd0, 1'b0, 1'b0};
    run_line(10, w, 1'b1, 1'b0, 1'b0);
    // completion and new request in the same cycle
    w = '{32'h8000_0008, 1'b1, 4'd2, 4'd1, 2'd0, 1'b1, 1'b0};
    run_line(20, w, 1'b0, 1'b1, 1'b0);
    w = '{32'h0000_2004, 1'b0, 4'd0, 4'd0, 2'd0, 1'b0, 1'b0};
    run_line(21, w, 1'b0, 1'b0, 1'b1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule